// File: doc/BRIEF.md
# Cache Hit/Miss Timing Tracker

This block charges level-one cache timing without holding any data. It keeps, per set, the tags of a two-way set-associative cache, one valid bit per way and one recency bit. For every accepted request it decides hit or miss, refreshes the recency state, and installs the line when a read misses. A request that misses holds the requester off for a fixed number of clocks. When timing is switched off, the same lookups and allocations happen but no stall is charged, so clock counts no longer depend on cache geometry.

A core model places the tracker next to its functional memory path. Each load or store address is presented with a read/write flag. The result and a one-clock hit or miss event come back on the clock after acceptance. Three running totals (accesses, hits, misses) let a harness compare the observed miss count with what an access pattern should produce.

Top module: `cache_timing_tracker`

## Requirements
- R1: After reset, every valid bit is clear, busy and all response and event outputs are 0, req_ready is 1, and all three counters read 0. The first read to any line therefore misses.
- R2: A line spans 32 bytes. The set index is `req_addr[5 +: log2(SETS)]` and the tag is every bit above the index. Byte-offset bits 4:0 never change the outcome, and two addresses with the same index and tag hit the same line.
- R3: A read miss installs its line, so a following read of that line hits. A write miss installs nothing, so a following read of that line still misses.
- R4: A fill goes into way 0 if that way is invalid, then into way 1 if that way is invalid, and otherwise into the least recently used way. A hit or a fill makes the other way of that set the least recently used. With A, B and C mapping to one set, the read sequence A, B, A, C evicts B and keeps A.
- R5: When req_valid is high and busy is low, the request is accepted. With timing on, a miss raises busy on the clock after acceptance and holds it for exactly PENALTY (default 8) cycles. req_ready is the inverse of busy. A hit never raises busy.
- R6: When timing_en is low at acceptance, a miss raises no busy. Tag, valid and recency updates are the same as with timing on.
- R7: Exactly one of hit_pulse and miss_pulse is high, for one cycle, on the clock after each accepted request. In that same cycle resp_valid is 1 and resp_hit equals hit_pulse. With no acceptance, both pulses are 0.
- R8: cnt_access, cnt_hit and cnt_miss each add one per accepted access, hit and miss respectively. The new value is visible on the clock after acceptance, and cnt_access always equals cnt_hit + cnt_miss.
- R9: Reading lines sequentially at a 32-byte stride hits on every access of a second pass once the working set is at most 2·SETS lines. With 3·SETS lines in rotation, every access misses on every pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timing_en | input | 1 | 1: misses charge the stall penalty; 0: no stall |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Byte address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ready | output | 1 | Tracker can accept a request this cycle |
| resp_valid | output | 1 | Result of the previous accepted request |
| resp_hit | output | 1 | That result was a hit |
| busy | output | 1 | Miss penalty in progress |
| hit_pulse | output | 1 | One-cycle hit event |
| miss_pulse | output | 1 | One-cycle miss event |
| cnt_access | output | CNT_W | Total accepted accesses |
| cnt_hit | output | CNT_W | Total hits |
| cnt_miss | output | CNT_W | Total misses |

## Verification
Two things can happen in the same clock: reporting the result of one access, and accepting and looking up the next access to the same set. The second lookup must already see the fill and recency update made by the first. The bench provokes this by presenting each new request in the cycle where the previous response is out, with timing off and on, in directed same-set sequences and in random traffic confined to a few sets. Each outcome is judged against a reference model of tags, valid bits and recency bits kept in the bench.

// File: rtl/ctt_pkg.sv
package ctt_pkg;

  typedef enum logic [1:0] {
    OUT_HIT       = 2'd0,
    OUT_MISS_FILL = 2'd1,
    OUT_MISS_PASS = 2'd2
  } outcome_e;

  function automatic logic pick_fill_way(input logic v0, input logic v1, input logic lru);
    if (!v0)      return 1'b0;
    else if (!v1) return 1'b1;
    else          return lru;
  endfunction

endpackage

// File: rtl/ctt_tag_way.sv
module ctt_tag_way #(
  parameter int SETS  = 128,
  parameter int IDX_W = 7,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_vld,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [TAG_W-1:0] tag_mem [SETS];
  logic [SETS-1:0]  vld_q;

  // tag array: no reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (rst)        vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  assign rd_tag = tag_mem[rd_idx];
  assign rd_vld = vld_q[rd_idx];
endmodule

// File: rtl/ctt_lru_bits.sv
module ctt_lru_bits #(
  parameter int SETS  = 128,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  output logic             lru_way,
  input  logic             upd,
  input  logic             used_way
);
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk) begin
    if (rst)      lru_q <= '0;
    else if (upd) lru_q[idx] <= ~used_way;
  end

  assign lru_way = lru_q[idx];
endmodule

// File: rtl/ctt_stall_timer.sv
module ctt_stall_timer #(
  parameter int PENALTY = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(PENALTY + 1);
  localparam logic [CW-1:0] LOAD = CW'(PENALTY);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)              left_q <= '0;
    else if (start)       left_q <= LOAD;
    else if (left_q != 0) left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/cache_timing_tracker.sv
module cache_timing_tracker #(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 128,
  parameter int LINE_BYTES = 32,
  parameter int PENALTY    = 8,
  parameter int CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              timing_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              busy,
  output logic              hit_pulse,
  output logic              miss_pulse,
  output logic [CNT_W-1:0]  cnt_access,
  output logic [CNT_W-1:0]  cnt_hit,
  output logic [CNT_W-1:0]  cnt_miss
);
  import ctt_pkg::*;

  localparam int WAYS  = 2;
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic             accept;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic [TAG_W-1:0] way_tag [WAYS];
  logic [WAYS-1:0]  way_vld;
  logic [WAYS-1:0]  way_hit;
  logic [WAYS-1:0]  way_wr;
  logic             lru_way;
  logic             fill_way;
  logic             used_way;
  logic             any_hit;
  logic             stall_busy;
  outcome_e         outcome;

  assign idx    = req_addr[OFF_W +: IDX_W];
  assign tag    = req_addr[ADDR_W-1 -: TAG_W];
  assign accept = req_valid && !stall_busy;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    ctt_tag_way #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_way (
      .clk    (clk),
      .rst    (rst),
      .rd_idx (idx),
      .rd_tag (way_tag[w]),
      .rd_vld (way_vld[w]),
      .wr_en  (way_wr[w]),
      .wr_idx (idx),
      .wr_tag (tag)
    );
    assign way_hit[w] = way_vld[w] && (way_tag[w] == tag);
    assign way_wr[w]  = (outcome == OUT_MISS_FILL) && accept && (fill_way == 1'(w));
  end

  assign any_hit  = |way_hit;
  assign fill_way = pick_fill_way(way_vld[0], way_vld[1], lru_way);
  assign used_way = any_hit ? way_hit[1] : fill_way;

  always_comb begin
    if (any_hit)        outcome = OUT_HIT;
    else if (req_write) outcome = OUT_MISS_PASS;
    else                outcome = OUT_MISS_FILL;
  end

  ctt_lru_bits #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
    .clk      (clk),
    .rst      (rst),
    .idx      (idx),
    .lru_way  (lru_way),
    .upd      (accept && (outcome != OUT_MISS_PASS)),
    .used_way (used_way)
  );

  ctt_stall_timer #(.PENALTY(PENALTY)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (accept && !any_hit && timing_en),
    .busy  (stall_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      hit_pulse  <= 1'b0;
      miss_pulse <= 1'b0;
      cnt_access <= '0;
      cnt_hit    <= '0;
      cnt_miss   <= '0;
    end else begin
      resp_valid <= accept;
      resp_hit   <= accept && any_hit;
      hit_pulse  <= accept && any_hit;
      miss_pulse <= accept && !any_hit;
      if (accept) begin
        cnt_access <= cnt_access + 1'b1;
        if (any_hit) cnt_hit  <= cnt_hit + 1'b1;
        else         cnt_miss <= cnt_miss + 1'b1;
      end
    end
  end

  assign busy      = stall_busy;
  assign req_ready = !stall_busy;
endmodule

// File: rtl/ctt_checker.sv
module ctt_checker #(
  parameter int PENALTY = 8,
  parameter int CNT_W   = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             timing_en,
  input logic             req_valid,
  input logic             req_ready,
  input logic             busy,
  input logic             hit_pulse,
  input logic             miss_pulse,
  input logic [CNT_W-1:0] cnt_access,
  input logic [CNT_W-1:0] cnt_hit,
  input logic [CNT_W-1:0] cnt_miss
);
  localparam int RW = $clog2(PENALTY + 1) + 1;
  logic [RW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  p_ready_blocked_r5: assert property (@(posedge clk) disable iff (rst) busy |-> !req_ready);
  p_ready_idle_r5:    assert property (@(posedge clk) disable iff (rst) !busy |-> req_ready);
  p_busy_cap_r5:      assert property (@(posedge clk) disable iff (rst) busy |-> (run_len < RW'(PENALTY)));
  p_busy_len_r5:      assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> (run_len == RW'(PENALTY)));
  p_busy_cause_r6:    assert property (@(posedge clk) disable iff (rst)
                        $rose(busy) |-> $past(req_valid && req_ready && timing_en));
  p_one_outcome_r7:   assert property (@(posedge clk) disable iff (rst) !(hit_pulse && miss_pulse));
  p_pulse_cause_r7:   assert property (@(posedge clk) disable iff (rst)
                        (hit_pulse || miss_pulse) |-> $past(req_valid && req_ready));
  p_count_sum_r8:     assert property (@(posedge clk) disable iff (rst)
                        cnt_access == CNT_W'(cnt_hit + cnt_miss));
endmodule

bind cache_timing_tracker ctt_checker #(.PENALTY(PENALTY), .CNT_W(CNT_W)) u_ctt_checker (
  .clk        (clk),
  .rst        (rst),
  .timing_en  (timing_en),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .busy       (busy),
  .hit_pulse  (hit_pulse),
  .miss_pulse (miss_pulse),
  .cnt_access (cnt_access),
  .cnt_hit    (cnt_hit),
  .cnt_miss   (cnt_miss)
);

// File: tb/cache_timing_tracker_bench.sv
module cache_timing_tracker_bench;
  localparam int AW   = 32;
  localparam int SETS = 128;
  localparam int PEN  = 8;
  localparam int IW   = $clog2(SETS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic timing_en = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_write = 1'b0;
  logic req_ready, resp_valid, resp_hit, busy, hit_pulse, miss_pulse;
  logic [31:0] cnt_access, cnt_hit, cnt_miss;

  int checks = 0;
  int errors = 0;
  int n_acc = 0, n_hit = 0, n_miss = 0;

  // reference model
  logic [AW-1:0] m_tag [SETS][2];
  bit            m_vld [SETS][2];
  bit            m_lru [SETS];

  always #2 clk = ~clk;

  cache_timing_tracker #(.ADDR_W(AW), .SETS(SETS), .LINE_BYTES(32), .PENALTY(PEN), .CNT_W(32)) u_cache_timing_tracker (
    .clk(clk), .rst(rst), .timing_en(timing_en), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .busy(busy), .hit_pulse(hit_pulse), .miss_pulse(miss_pulse),
    .cnt_access(cnt_access), .cnt_hit(cnt_hit), .cnt_miss(cnt_miss)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int set_of(input logic [AW-1:0] a);
    return int'(a[5 +: IW]);
  endfunction

  function automatic logic [AW-1:0] tag_of(input logic [AW-1:0] a);
    return a >> (5 + IW);
  endfunction

  function automatic bit model_hit(input logic [AW-1:0] a);
    int s = set_of(a);
    return (m_vld[s][0] && m_tag[s][0] == tag_of(a)) || (m_vld[s][1] && m_tag[s][1] == tag_of(a));
  endfunction

  function automatic void model_update(input logic [AW-1:0] a, input bit wr);
    int s = set_of(a);
    int w;
    if (m_vld[s][0] && m_tag[s][0] == tag_of(a))      m_lru[s] = 1'b1;
    else if (m_vld[s][1] && m_tag[s][1] == tag_of(a)) m_lru[s] = 1'b0;
    else if (!wr) begin
      w = !m_vld[s][0] ? 0 : (!m_vld[s][1] ? 1 : int'(m_lru[s]));
      m_vld[s][w] = 1'b1;
      m_tag[s][w] = tag_of(a);
      m_lru[s]    = (w == 0);
    end
  endfunction

  // entered and left at a negedge
  task automatic acc(input logic [AW-1:0] a, input bit wr, input bit te, input string req, output bit got_hit);
    bit exp_hit;
    int n;
    while (!req_ready) @(negedge clk);
    exp_hit = model_hit(a);
    req_valid = 1'b1; req_addr = a; req_write = wr; timing_en = te;
    @(negedge clk);
    req_valid = 1'b0;
    got_hit = resp_hit;
    chk(resp_valid && resp_hit == exp_hit, req, resp_hit, exp_hit);
    chk(hit_pulse == exp_hit && miss_pulse == !exp_hit, "R7 event pulse", {hit_pulse, miss_pulse}, {exp_hit, !exp_hit});
    model_update(a, wr);
    n_acc++;
    if (exp_hit) n_hit++; else n_miss++;
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    if (exp_hit)  chk(n == 0, "R5 hit stalls", n, 0);
    else if (te)  chk(n == PEN, "R5 miss penalty length", n, PEN);
    else          chk(n == 0, "R6 untimed miss stalls", n, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    foreach (m_vld[s]) begin
      m_vld[s][0] = 0; m_vld[s][1] = 0; m_lru[s] = 0;
    end
    n_acc = 0; n_hit = 0; n_miss = 0;
    chk(!busy && req_ready && !resp_valid && !hit_pulse && !miss_pulse, "R1 reset outputs",
        {busy, req_ready, resp_valid}, 3'b010);
    chk(cnt_access == 0 && cnt_hit == 0 && cnt_miss == 0, "R1 reset counters", cnt_access, 0);
  endtask

  task automatic chk_counters(input string tagline);
    chk(cnt_access == n_acc, {tagline, " R8 access count"}, cnt_access, n_acc);
    chk(cnt_hit == n_hit, {tagline, " R8 hit count"}, cnt_hit, n_hit);
    chk(cnt_miss == n_miss, {tagline, " R8 miss count"}, cnt_miss, n_miss);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit h;
    logic [AW-1:0] A, B, C;
    A = 32'h0000_0040;
    B = A + SETS * 32;
    C = A + 2 * SETS * 32;

    @(negedge clk);
    do_reset();

    // R1 / R2: first read misses, offset bits do not matter, index bit 5 does
    acc(32'h0000_1000, 0, 1, "R1 cold read miss", h);
    acc(32'h0000_101F, 0, 1, "R2 same line other offset hits", h);
    acc(32'h0000_1020, 0, 1, "R2 neighbour index misses", h);

    // R3: write miss allocates nothing
    acc(32'h0000_3000, 1, 1, "R3 write miss", h);
    acc(32'h0000_3000, 0, 1, "R3 read after write miss still misses", h);
    acc(32'h0000_3000, 0, 1, "R3 read after read fill hits", h);
    acc(32'h0000_3004, 1, 0, "R3 write hit", h);

    // R4: A, B, A, C then A hits and B misses; back-to-back same set
    acc(A, 0, 0, "R4 fill way0", h);
    acc(B, 0, 0, "R4 fill way1", h);
    acc(A, 0, 0, "R4 refresh A", h);
    acc(C, 0, 1, "R4 evict lru", h);
    acc(A, 0, 0, "R4 A kept", h);
    chk(h == 1, "R4 A survives", h, 1);
    acc(B, 0, 0, "R4 B evicted", h);
    chk(h == 0, "R4 B gone", h, 0);
    chk_counters("directed");

    // R6: timing off leaves state consistent
    acc(32'h0004_0000, 0, 0, "R6 untimed fill", h);
    acc(32'h0004_0000, 0, 1, "R6 timed hit after untimed fill", h);

    // random traffic confined to four sets and eight tags
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      a = ($urandom_range(0, 7) << (5 + IW)) | ($urandom_range(0, 3) << 5) | $urandom_range(0, 31);
      acc(a, ($urandom_range(0, 3) == 0), $urandom_range(0, 1), "R4 random reference", h);
    end
    chk_counters("random");

    // R9: stride fits
    do_reset();
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 2 * SETS; i++)
        acc(AW'(i * 32), 0, 0, "R9 stride fitting set", h);
    chk(cnt_hit == 2 * SETS, "R9 second pass all hits", cnt_hit, 2 * SETS);

    // R9: stride thrashes
    do_reset();
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 3 * SETS; i++)
        acc(AW'(i * 32), 0, 0, "R9 stride thrashing set", h);
    chk(cnt_miss == 6 * SETS && cnt_hit == 0, "R9 every access misses", cnt_miss, 6 * SETS);
    chk_counters("stride");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule